// File: doc/BRIEF.md
# MII Management Frame Register with PHY Register Emulation

This block gives a host a single 32-bit management command register through which it issues MII management read and write operations. No serial MDIO frame is shifted out. A write to the command register is decoded straight away, and the command runs against an internal bank of 32 sixteen-bit PHY registers. When the command is done, the low turnaround bit is set. Software polls that bit to learn that the operation is complete. After a read command, software collects the result from the low half of the same register.

The emulated PHY answers on one fixed address. It behaves like a real transceiver in these ways:

- The software reset bit and the negotiation-restart bit in its control register clear themselves.
- A restart reports negotiation complete.
- The link state follows a `link_up` input.
- Every link change loads a management interrupt status register that clears when read.
- The interrupt output is raised when a status bit is set and its mask bit is clear.

A configuration register sits beside these registers. Two of its bits are read-only.

The host selects a register with a 2-bit select: 0 = command frame, 1 = configuration, 2 = interrupt mask, 3 = interrupt status. Reads are combinational in the cycle of the read strobe. Writes take effect at the next clock edge.

Top module: `mii_mgmt_emu`

## Requirements
- R1: Command frame layout: start code [31:30], opcode [29:28], PHY address [27:23], register address [22:18], turnaround [17:16], data [15:0]. After any host write to select 0, the frame register reads back the written word with bit 16 forced to 1.
- R2: A valid read (start 01, PHY address 1, opcode 10) replaces frame bits [15:0] with the addressed PHY register. All other frame bits keep the written value.
- R3: A valid write (start 01, PHY address 1, opcode 01) stores frame data [15:0] into the addressed PHY register. Opcodes 00 and 11 change no PHY register and leave the written data in the frame.
- R4: A start code other than 01, or a PHY address other than 1, aborts the command. No PHY register changes, and the frame holds the written word with bit 16 set.
- R5: A write to PHY register 0 with bit 15 (reset) set stores the word with bit 15 cleared and bit 12 (negotiation enable) set.
- R6: A write to PHY register 0 with bit 9 (restart) set stores the word with bit 9 cleared and sets bit 5 (negotiation complete) of PHY register 1. If `link_up` is 1 at that time, it also sets bit 2 (link) of register 1 and bit 8 (partner 100 Mb/s full duplex) of register 5.
- R7: When `link_up` changes, register 1 bit 2 and register 5 bit 8 take the new level. The interrupt status register becomes 0xFFFF one clock later.
- R8: A read of the interrupt status register (select 3) returns its current value, and the register is 0 from the next clock on. Host writes to it have no effect.
- R9: `irq` is 1 exactly when some interrupt status bit is 1 while the same bit of the 16-bit mask (select 2) is 0.
- R10: Configuration bits 9 and 8 ignore host writes. All other configuration bits store the written value.
- R11: After reset:
  - frame = 0, configuration = 0x00000100, mask = 0xFFFF, interrupt status = 0.
  - PHY register 1 = 0x4028 (100 Mb/s full duplex, negotiation ability, negotiation complete).
  - register 4 = 0x0100, registers 2 and 3 hold the identifier parameters (0x0123, 0x4567), and all other registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_sel | input | 2 | Register select: 0 frame, 1 config, 2 mask, 3 status |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid while host_rd is 1, else 0 |
| link_up | input | 1 | Link state of the emulated PHY |
| irq | output | 1 | Management interrupt request |

## Verification
The command register is driven with several kinds of frame:
- Valid reads and writes, which show that decode, storage and read-back line up.
- Frames with a bad start code or a foreign PHY address. Each is followed by a read of the same register, which shows that an abort leaves the bank untouched.
- Unused opcodes, which show that only the 01 and 10 codes act.
- Control words carrying the reset or restart bit, alone and together. These are checked with the link both down and up, so that the link-dependent side effects are told apart from the unconditional ones.
- Link transitions combined with different mask values, which separate the clear-on-read timing from the interrupt gating.

// File: rtl/mii_mgmt_pkg.sv
package mii_mgmt_pkg;

   localparam int HOST_W    = 32;
   localparam int PHY_DW    = 16;
   localparam int RA_W      = 5;
   localparam int PA_W      = 5;

   typedef enum logic [1:0] {
      SEL_FRAME = 2'd0,
      SEL_CFG   = 2'd1,
      SEL_MASK  = 2'd2,
      SEL_STAT  = 2'd3
   } host_sel_e;

   // command frame, msb first
   typedef struct packed {
      logic [1:0]      st;
      logic [1:0]      opc;
      logic [PA_W-1:0] phy;
      logic [RA_W-1:0] ra;
      logic [1:0]      ta;
      logic [15:0]     data;
   } frame_t;

   localparam logic [1:0] START_CODE = 2'b01;
   localparam logic [1:0] OPC_WRITE  = 2'b01;
   localparam logic [1:0] OPC_READ   = 2'b10;
   localparam int         TA_LSB     = 16;

   // emulated PHY register indices
   localparam int PR_CTRL    = 0;
   localparam int PR_STAT    = 1;
   localparam int PR_ID_HI   = 2;
   localparam int PR_ID_LO   = 3;
   localparam int PR_ADV     = 4;
   localparam int PR_PARTNER = 5;

   // bit positions
   localparam int CTRL_RESET   = 15;
   localparam int CTRL_AN_EN   = 12;
   localparam int CTRL_RESTART = 9;
   localparam int STAT_LINK    = 2;
   localparam int STAT_AN_DONE = 5;
   localparam int ABIL_100FD   = 8;

   localparam logic [PHY_DW-1:0] STAT_RST = 16'h4028;
   localparam logic [PHY_DW-1:0] ADV_RST  = 16'h0100;

endpackage

// File: rtl/mgmt_frame_decode.sv
module mgmt_frame_decode
   import mii_mgmt_pkg::*;
#(
   parameter int PHY_ADDR = 1
) (
   input  logic [HOST_W-1:0] word,
   output logic              cmd_ok,
   output logic              cmd_wr,
   output logic              cmd_rd,
   output logic [RA_W-1:0]   cmd_ra,
   output logic [PHY_DW-1:0] cmd_data
);

   frame_t fr;

   always_comb begin
      fr       = frame_t'(word);
      cmd_ok   = (fr.st == START_CODE) && (fr.phy == PA_W'(PHY_ADDR));
      cmd_wr   = cmd_ok && (fr.opc == OPC_WRITE);
      cmd_rd   = cmd_ok && (fr.opc == OPC_READ);
      cmd_ra   = fr.ra;
      cmd_data = fr.data;
   end

endmodule

// File: rtl/phy_reg_bank.sv
module phy_reg_bank
   import mii_mgmt_pkg::*;
#(
   parameter int               NUM_REGS = 32,
   parameter logic [PHY_DW-1:0] ID_HI   = 16'h0123,
   parameter logic [PHY_DW-1:0] ID_LO   = 16'h4567
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [RA_W-1:0]   wr_addr,
   input  logic [PHY_DW-1:0] wr_data,
   input  logic [RA_W-1:0]   rd_addr,
   output logic [PHY_DW-1:0] rd_data,
   input  logic              link_up,
   input  logic              link_evt
);

   localparam int IDX_W = $clog2(NUM_REGS);

   if (NUM_REGS != (1 << RA_W)) begin : g_bad_depth
      $error("phy_reg_bank: NUM_REGS must match the register address field");
   end

   function automatic logic [PHY_DW-1:0] rst_val(int idx);
      case (idx)
         PR_STAT:  return STAT_RST;
         PR_ID_HI: return ID_HI;
         PR_ID_LO: return ID_LO;
         PR_ADV:   return ADV_RST;
         default:  return '0;
      endcase
   endfunction

   logic [NUM_REGS-1:0][PHY_DW-1:0] regs_flat;
   logic                            restart;
   logic [PHY_DW-1:0]               ctrl_word;

   always_comb begin
      restart   = wr_en && (wr_addr == RA_W'(PR_CTRL)) && wr_data[CTRL_RESTART];
      ctrl_word = wr_data;
      ctrl_word[CTRL_RESTART] = 1'b0;
      if (wr_data[CTRL_RESET]) begin
         ctrl_word[CTRL_RESET] = 1'b0;
         ctrl_word[CTRL_AN_EN] = 1'b1;
      end
   end

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      logic [PHY_DW-1:0] q;
      logic [PHY_DW-1:0] d;

      always_comb begin
         d = q;
         if (wr_en && (wr_addr == RA_W'(i))) begin
            d = (i == PR_CTRL) ? ctrl_word : wr_data;
         end
         if (i == PR_STAT) begin
            if (restart) begin
               d[STAT_AN_DONE] = 1'b1;
               if (link_up) d[STAT_LINK] = 1'b1;
            end
            if (link_evt) d[STAT_LINK] = link_up;
         end
         if (i == PR_PARTNER) begin
            if (restart && link_up) d[ABIL_100FD] = 1'b1;
            if (link_evt)           d[ABIL_100FD] = link_up;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= rst_val(i);
         else        q <= d;
      end

      assign regs_flat[i] = q;
   end

   assign rd_data = regs_flat[IDX_W'(rd_addr)];

endmodule

// File: rtl/mgmt_irq_ctrl.sv
module mgmt_irq_ctrl
   import mii_mgmt_pkg::*;
#(
   parameter int STAT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mask_wr,
   input  logic [STAT_W-1:0] mask_wdata,
   input  logic              stat_rd,
   input  logic              link_evt,
   output logic [STAT_W-1:0] stat_q,
   output logic [STAT_W-1:0] mask_q,
   output logic              irq
);

   if (STAT_W < 1 || STAT_W > HOST_W) begin : g_bad_w
      $error("mgmt_irq_ctrl: STAT_W out of range");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         mask_q <= '1;
      end else begin
         if (link_evt)     stat_q <= '1;
         else if (stat_rd) stat_q <= '0;
         if (mask_wr) mask_q <= mask_wdata;
      end
   end

   assign irq = |(stat_q & ~mask_q);

endmodule

// File: rtl/mii_mgmt_emu.sv
module mii_mgmt_emu
   import mii_mgmt_pkg::*;
#(
   parameter int                PHY_ADDR     = 1,
   parameter int                NUM_PHY_REGS = 32,
   parameter logic [PHY_DW-1:0] PHY_ID_HI    = 16'h0123,
   parameter logic [PHY_DW-1:0] PHY_ID_LO    = 16'h4567,
   parameter logic [HOST_W-1:0] CFG_RO_MASK  = 32'h0000_0300,
   parameter logic [HOST_W-1:0] CFG_RST      = 32'h0000_0100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [1:0]        host_sel,
   input  logic [HOST_W-1:0] host_wdata,
   output logic [HOST_W-1:0] host_rdata,
   input  logic              link_up,
   output logic              irq
);

   localparam int STAT_W = PHY_DW;

   if (PHY_ADDR < 0 || PHY_ADDR >= (1 << PA_W)) begin : g_bad_addr
      $error("mii_mgmt_emu: PHY_ADDR does not fit the address field");
   end

   logic              link_q;
   logic              link_evt;
   logic              cmd_ok, cmd_wr, cmd_rd;
   logic [RA_W-1:0]   cmd_ra;
   logic [PHY_DW-1:0] cmd_data;
   logic [PHY_DW-1:0] bank_rd;
   logic              frame_wr, cfg_wr, mask_wr, stat_rd;
   logic [HOST_W-1:0] frame_q, frame_d, cfg_q;
   logic [STAT_W-1:0] stat_q, mask_q;

   always_comb begin
      frame_wr = host_wr && (host_sel == SEL_FRAME);
      cfg_wr   = host_wr && (host_sel == SEL_CFG);
      mask_wr  = host_wr && (host_sel == SEL_MASK);
      stat_rd  = host_rd && (host_sel == SEL_STAT);
      link_evt = link_q != link_up;
   end

   mgmt_frame_decode #(.PHY_ADDR(PHY_ADDR)) u_dec (
      .word     (host_wdata),
      .cmd_ok   (cmd_ok),
      .cmd_wr   (cmd_wr),
      .cmd_rd   (cmd_rd),
      .cmd_ra   (cmd_ra),
      .cmd_data (cmd_data)
   );

   phy_reg_bank #(
      .NUM_REGS (NUM_PHY_REGS),
      .ID_HI    (PHY_ID_HI),
      .ID_LO    (PHY_ID_LO)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (frame_wr && cmd_wr),
      .wr_addr  (cmd_ra),
      .wr_data  (cmd_data),
      .rd_addr  (cmd_ra),
      .rd_data  (bank_rd),
      .link_up  (link_up),
      .link_evt (link_evt)
   );

   mgmt_irq_ctrl #(.STAT_W(STAT_W)) u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .mask_wr    (mask_wr),
      .mask_wdata (host_wdata[STAT_W-1:0]),
      .stat_rd    (stat_rd),
      .link_evt   (link_evt),
      .stat_q     (stat_q),
      .mask_q     (mask_q),
      .irq        (irq)
   );

   always_comb begin
      frame_d         = host_wdata;
      frame_d[TA_LSB] = 1'b1;
      if (cmd_ok && cmd_rd) frame_d[PHY_DW-1:0] = bank_rd;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_q <= '0;
         cfg_q   <= CFG_RST;
         link_q  <= 1'b0;
      end else begin
         link_q <= link_up;
         if (frame_wr) frame_q <= frame_d;
         if (cfg_wr)   cfg_q   <= (host_wdata & ~CFG_RO_MASK) | (cfg_q & CFG_RO_MASK);
      end
   end

   always_comb begin
      host_rdata = '0;
      if (host_rd) begin
         case (host_sel)
            SEL_FRAME: host_rdata = frame_q;
            SEL_CFG:   host_rdata = cfg_q;
            SEL_MASK:  host_rdata = HOST_W'(mask_q);
            default:   host_rdata = HOST_W'(stat_q);
         endcase
      end
   end

endmodule

// File: rtl/mii_mgmt_emu_chk.sv
module mii_mgmt_emu_chk
   import mii_mgmt_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              host_wr,
   input logic              host_rd,
   input logic [1:0]        host_sel,
   input logic [HOST_W-1:0] host_wdata,
   input logic              link_evt,
   input logic              irq,
   input logic [HOST_W-1:0] frame_q,
   input logic [HOST_W-1:0] cfg_q,
   input logic [15:0]       stat_q,
   input logic [15:0]       mask_q
);

   // R1
   ta_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_sel == SEL_FRAME) |=> frame_q[TA_LSB]);

   // R4
   abort_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_sel == SEL_FRAME && host_wdata[31:30] != START_CODE)
      |=> frame_q[15:0] == $past(host_wdata[15:0]));

   // R10
   cfg_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_sel == SEL_CFG) |=> $stable(cfg_q[9:8]));

   // R8
   stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && host_sel == SEL_STAT && !link_evt) |=> stat_q == 16'h0000);

   // R7
   link_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      link_evt |=> stat_q == 16'hFFFF);

   // R9
   mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == 16'hFFFF) |-> !irq);

endmodule

bind mii_mgmt_emu mii_mgmt_emu_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_wr    (host_wr),
   .host_rd    (host_rd),
   .host_sel   (host_sel),
   .host_wdata (host_wdata),
   .link_evt   (link_evt),
   .irq        (irq),
   .frame_q    (frame_q),
   .cfg_q      (cfg_q),
   .stat_q     (stat_q),
   .mask_q     (mask_q)
);

// File: tb/test_mii_mgmt_emu.sv
module test_mii_mgmt_emu;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0;
   logic        host_rd = 1'b0;
   logic [1:0]  host_sel = 2'd0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        link_up = 1'b0;
   logic        irq;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   mii_mgmt_emu i_mii_mgmt_emu (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_wr    (host_wr),
      .host_rd    (host_rd),
      .host_sel   (host_sel),
      .host_wdata (host_wdata),
      .host_rdata (host_rdata),
      .link_up    (link_up),
      .irq        (irq)
   );

   function automatic logic [31:0] mk(logic [1:0] st, logic [1:0] op, logic [4:0] pa,
                                      logic [4:0] ra, logic [15:0] d);
      return {st, op, pa, ra, 2'b00, d};
   endfunction

   function automatic logic [31:0] ta(logic [31:0] w, logic [15:0] d);
      return {w[31:17], 1'b1, d};
   endfunction

   localparam int NV = 27;
   localparam logic [31:0] VIN [NV] = '{
      mk(1,2,1,1,16'h0000),  // R11 status reset value
      mk(1,1,1,7,16'hA5A5),  // R3
      mk(1,2,1,7,16'h0000),  // R2
      mk(1,2,2,7,16'h1234),  // R4 foreign address
      mk(0,1,1,7,16'hFFFF),  // R4 bad start
      mk(1,2,1,7,16'h0000),  // R4
      mk(1,1,0,7,16'h0000),  // R4 address 0
      mk(1,2,1,7,16'h0000),  // R4
      mk(1,3,1,7,16'h5555),  // R3 opcode 11
      mk(1,0,1,7,16'h6666),  // R3 opcode 00
      mk(1,2,1,7,16'h0000),  // R3
      mk(1,2,1,2,16'h0000),  // R11 id hi
      mk(1,2,1,3,16'h0000),  // R11 id lo
      mk(1,2,1,4,16'h0000),  // R11 advert
      mk(1,1,1,0,16'h8000),  // R5
      mk(1,2,1,0,16'h0000),  // R5
      mk(1,1,1,1,16'h0000),  // R3
      mk(1,2,1,1,16'h0000),  // R3
      mk(1,1,1,0,16'h0200),  // R6
      mk(1,2,1,0,16'h0000),  // R6
      mk(1,2,1,1,16'h0000),  // R6 done bit, no link
      mk(1,2,1,5,16'h0000),  // R6 partner untouched
      mk(1,1,1,31,16'hFFFF), // R3 top address
      mk(1,2,1,31,16'h0000), // R2
      mk(3,2,1,31,16'h0000), // R4 start 11
      mk(1,1,1,0,16'h8200),  // R5 R6 together
      mk(1,2,1,0,16'h0000)   // R5
   };
   localparam logic [15:0] VEXP [NV] = '{
      16'h4028, 16'hA5A5, 16'hA5A5, 16'h1234, 16'hFFFF, 16'hA5A5, 16'h0000,
      16'hA5A5, 16'h5555, 16'h6666, 16'hA5A5, 16'h0123, 16'h4567, 16'h0100,
      16'h8000, 16'h1000, 16'h0000, 16'h0000, 16'h0200, 16'h0000, 16'h0020,
      16'h0000, 16'hFFFF, 16'hFFFF, 16'h0000, 16'h8200, 16'h1000
   };
   localparam int VREQ [NV] = '{
      11, 3, 2, 4, 4, 4, 4, 4, 3, 3, 3, 11, 11, 11,
      5, 5, 3, 3, 6, 6, 6, 6, 3, 2, 4, 5, 5
   };

   task automatic check(string req, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic hwrite(logic [1:0] sel, logic [31:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_sel = sel; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic hread(logic [1:0] sel, output logic [31:0] d);
      @(negedge clk);
      host_rd = 1'b1; host_sel = sel;
      #1 d = host_rdata;
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic phy_read(logic [4:0] ra, output logic [15:0] d);
      logic [31:0] w;
      hwrite(2'd0, mk(1,2,1,ra,16'h0000));
      hread(2'd0, w);
      d = w[15:0];
   endtask

   task automatic set_link(logic v);
      @(negedge clk);
      link_up = v;
      @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      logic [15:0] p;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R11 reset state
      hread(2'd0, r); check("R11 frame", r, 32'h0);
      hread(2'd1, r); check("R11 config", r, 32'h0000_0100);
      hread(2'd2, r); check("R11 mask", r, 32'h0000_FFFF);
      hread(2'd3, r); check("R11 status", r, 32'h0);
      check("R11 irq", {31'b0, irq}, 32'h0);

      // table walk, link down
      for (int k = 0; k < NV; k++) begin
         hwrite(2'd0, VIN[k]);
         hread(2'd0, r);
         check($sformatf("R%0d vec%0d", VREQ[k], k), r, ta(VIN[k], VEXP[k]));
      end

      // R10 config read-only bits
      hwrite(2'd1, 32'hFFFF_FFFF);
      hread(2'd1, r); check("R10 cfg ones", r, 32'hFFFF_FDFF);
      hwrite(2'd1, 32'h0000_0000);
      hread(2'd1, r); check("R10 cfg zeros", r, 32'h0000_0100);

      // R7 link up, mask all set
      set_link(1'b1);
      check("R9 masked irq", {31'b0, irq}, 32'h0);
      hread(2'd3, r); check("R7 status set", r, 32'h0000_FFFF);
      hread(2'd3, r); check("R8 cleared", r, 32'h0);
      phy_read(5'd1, p); check("R7 link bit up", {16'h0, p}, 32'h0024);
      phy_read(5'd5, p); check("R7 partner up", {16'h0, p}, 32'h0100);
      set_link(1'b0);
      phy_read(5'd1, p); check("R7 link bit down", {16'h0, p}, 32'h0020);
      phy_read(5'd5, p); check("R7 partner down", {16'h0, p}, 32'h0000);
      hread(2'd3, r); check("R7 status on fall", r, 32'h0000_FFFF);

      // R6 restart with link up
      set_link(1'b1);
      hread(2'd3, r);
      hwrite(2'd0, mk(1,1,1,1,16'h0000));
      hwrite(2'd0, mk(1,1,1,5,16'h0000));
      hwrite(2'd0, mk(1,1,1,0,16'h0200));
      phy_read(5'd1, p); check("R6 link restart stat", {16'h0, p}, 32'h0024);
      phy_read(5'd5, p); check("R6 link restart partner", {16'h0, p}, 32'h0100);
      phy_read(5'd0, p); check("R6 restart self-clear", {16'h0, p}, 32'h0000);

      // R8 status not writable, R9 gating
      hwrite(2'd2, 32'h0000_FFFE);
      hread(2'd2, r); check("R9 mask readback", r, 32'h0000_FFFE);
      hwrite(2'd3, 32'h0000_FFFF);
      hread(2'd3, r); check("R8 write ignored", r, 32'h0);
      check("R9 irq idle", {31'b0, irq}, 32'h0);
      set_link(1'b0);
      check("R9 irq raised", {31'b0, irq}, 32'h1);
      hread(2'd3, r); check("R8 read value", r, 32'h0000_FFFF);
      check("R9 irq after clear", {31'b0, irq}, 32'h0);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule